// File: doc/BRIEF.md
# Cascadable Synchronous BCD Decade Counter

This block is a single decimal digit held in a four-bit register that steps through the 8421 BCD codes 0 to 9 and then wraps to 0. Every change of state happens on the rising clock edge. Four control inputs pick what the next edge does, in a fixed order of precedence:

- an active-low synchronous clear;
- an active-low synchronous parallel load;
- a count that needs two active-high enables;
- otherwise, hold.

One enable is a plain parallel enable. The other is a trickle enable that also qualifies the terminal-count output. Because of that, a digit's terminal count can drive the trickle enable of the next digit, and several digits form one synchronous multi-digit counter.

A load stores the data inputs exactly as presented, including the six unused codes 10 to 15. The count logic brings any such code back into the 0 to 9 cycle within two counts. A chip-level asynchronous active-low reset clears the register at once. Its release is synchronised to the clock before the counter may move.

Top module: `bcd_decade_counter`

## Requirements
- R1: While counting, the value steps 0,1,2,...,9 and 9 (binary 1001) is followed by 0 (binary 0000).
- R2: When `clr_n` is 0 at a rising edge, `q` becomes 0 after that edge, whatever `load_n`, `en_par`, `en_trk` and `din` are.
- R3: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `q` takes the value of `din` exactly after that edge, whatever the enables are. This includes codes 10 to 15.
- R4: When `clr_n` and `load_n` are both 1, the edge advances `q` only if `en_par` and `en_trk` are both 1. If either enable is 0, `q` keeps its value.
- R5: `tc` is 1 exactly when `en_trk` is 1 and `q` is 9. It is combinational and follows `en_trk` with no clock edge.
- R6: `tc` is 0 in every state other than 9, including codes 10 to 15, whatever `en_trk` is.
- R7: A count from an unused code gives the next value as follows: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2.
- R8: From any unused code, at most two consecutive counts give a value in 0 to 9.
- R9: While `rst_n` is 0, `q` is 0 without waiting for a clock. After `rst_n` rises, `q` stays 0 through the first two rising edges whatever the controls are, and the third edge is the first that can change it.
- R10: When two digits are chained, with the low digit's `tc` driving the high digit's `en_trk` and all other enables at 1, the pair counts 00 to 99 and wraps to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| clr_n | input | 1 | Synchronous clear, active low, highest precedence |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable, active high |
| en_trk | input | 1 | Trickle count enable, active high, also qualifies `tc` |
| din | input | 4 | Parallel data for a load |
| q | output | 4 | Current digit value |
| tc | output | 1 | Terminal count: digit is 9 and `en_trk` is 1 |

## Verification
The hardest conditions to reach from the ports are the unused codes 10 to 15. Counting never produces them, so each one must be planted with a parallel load. The next edge must then carry the chosen control combination. The bench loads every one of the 16 codes and applies each of the 16 clear/load/enable combinations on the following edge. It compares each result with a model built from the precedence rules and the recovery map. It also drives two counts in a row from each unused code to confirm the return to the legal range. Finally, a two-digit chain runs through a full hundred counts so that the carry through `tc` into the trickle enable is exercised at every 9-to-0 step.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2,
    MODE_HOLD  = 2'd3
  } mode_e;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcd_mode_decode.sv
module bcd_mode_decode
  import bcd_pkg::*;
(
  input  logic  clr_n,
  input  logic  load_n,
  input  logic  en_par,
  input  logic  en_trk,
  output mode_e mode
);
  always_comb begin
    if (!clr_n)                mode = MODE_CLEAR;
    else if (!load_n)          mode = MODE_LOAD;
    else if (en_par && en_trk) mode = MODE_COUNT;
    else                       mode = MODE_HOLD;
  end
endmodule

// File: rtl/bcd_next_state.sv
module bcd_next_state
  import bcd_pkg::*;
(
  input  mode_e              mode,
  input  logic [DIGIT_W-1:0] cur,
  input  logic [DIGIT_W-1:0] din,
  output logic [DIGIT_W-1:0] nxt
);
  logic [DIGIT_W-1:0] inc;

  // Successor on a count, including the recovery path for codes above nine.
  always_comb begin
    if (cur < DIGIT_MAX)       inc = cur + 1'b1;
    else if (cur == DIGIT_MAX) inc = '0;
    else if (!cur[0])          inc = cur + 1'b1;
    else begin
      case (cur)
        4'd11:   inc = 4'd6;
        4'd13:   inc = 4'd4;
        default: inc = 4'd2;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      MODE_CLEAR: nxt = '0;
      MODE_LOAD:  nxt = din;
      MODE_COUNT: nxt = inc;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [3:0]   din,
  output logic [3:0]   q,
  output logic         tc
);
  logic               rst_sync_n;
  mode_e              mode;
  logic [DIGIT_W-1:0] q_q;
  logic [DIGIT_W-1:0] q_d;
  logic               q_en;

  bcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcd_mode_decode u_mode (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .mode   (mode)
  );

  bcd_next_state u_next (
    .mode (mode),
    .cur  (q_q),
    .din  (din),
    .nxt  (q_d)
  );

  assign q_en = (mode != MODE_HOLD);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  q_q <= '0;
    else if (q_en)    q_q <= q_d;
  end

  assign q  = q_q;
  assign tc = en_trk & (q_q == DIGIT_MAX);

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_n |=> (q == 4'd0)); // R2
  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !load_n) |=> (q == $past(din))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && load_n && !(en_par && en_trk)) |=> $stable(q)); // R4
  AST_NINE_WRAPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && load_n && en_par && en_trk && q == 4'd9) |=> (q == 4'd0)); // R1
  AST_BACK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((clr_n && load_n && en_par && en_trk && q > 4'd9) ##1
     (clr_n && load_n && en_par && en_trk)) |=> (q <= 4'd9)); // R8
endmodule

// File: tb/bcd_decade_counter_tb.sv
module bcd_decade_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q;
  logic       tc;

  logic       c_clr_n = 1'b1;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bcd_decade_counter u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .en_par(en_par), .en_trk(en_trk), .din(din), .q(q), .tc(tc)
  );

  bcd_decade_counter u_lo (
    .clk(clk), .rst_n(rst_n), .clr_n(c_clr_n), .load_n(1'b1),
    .en_par(1'b1), .en_trk(1'b1), .din(4'd0), .q(lo_q), .tc(lo_tc)
  );

  bcd_decade_counter u_hi (
    .clk(clk), .rst_n(rst_n), .clr_n(c_clr_n), .load_n(1'b1),
    .en_par(1'b1), .en_trk(lo_tc), .din(4'd0), .q(hi_q), .tc(hi_tc)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] ref_count(input logic [3:0] s);
    case (s)
      4'd9:  return 4'd0;
      4'd10: return 4'd11;
      4'd11: return 4'd6;
      4'd12: return 4'd13;
      4'd13: return 4'd4;
      4'd14: return 4'd15;
      4'd15: return 4'd2;
      default: return s + 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] ref_next(input logic [3:0] s, input logic [3:0] c,
                                          input logic [3:0] d);
    if (!c[3])             return 4'd0;
    else if (!c[2])        return d;
    else if (c[1] && c[0]) return ref_count(s);
    else                   return s;
  endfunction

  task automatic t_reset();
    check("R9 q in reset", q, 0);
    clr_n = 1'b1; load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R9 q after 1st edge", q, 0);
    tick();
    check("R9 q after 2nd edge", q, 0);
    tick();
    check("R9 q after 3rd edge", q, 1);
    tick();
    rst_n = 1'b0;
    #1;
    check("R9 async clear", q, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(); tick();
  endtask

  task automatic t_sequence();
    clr_n = 1'b0; load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
    tick();
    clr_n = 1'b1;
    for (int i = 1; i <= 25; i++) begin
      tick();
      check("R1 count sequence", q, i % 10);
    end
  endtask

  task automatic t_exhaustive();
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        clr_n = 1'b1; load_n = 1'b0; en_par = 1'b0; en_trk = 1'b0;
        din = 4'(s);
        tick();
        check("R3 load exact", q, s);
        clr_n = c[3]; load_n = c[2]; en_par = c[1]; en_trk = c[0];
        din = ~4'(s);
        #1;
        check((s > 9) ? "R6 tc in unused code" : "R5 tc decode", tc,
              (c[0] && s == 9) ? 1 : 0);
        tick();
        check((s > 9 && c == 15) ? "R7 recovery map" :
              (!c[3] ? "R2 clear wins" : (!c[2] ? "R3 load wins" : "R4 count/hold")),
              q, ref_next(4'(s), 4'(c), ~4'(s)));
      end
    end
  endtask

  task automatic t_tc_comb();
    clr_n = 1'b1; load_n = 1'b0; en_par = 1'b0; en_trk = 1'b0; din = 4'd9;
    tick();
    load_n = 1'b1;
    #1 check("R5 tc low with en_trk 0", tc, 0);
    en_trk = 1'b1;
    #1 check("R5 tc follows en_trk high", tc, 1);
    en_trk = 1'b0;
    #1 check("R5 tc follows en_trk low", tc, 0);
    check("R4 hold with en_par 0", q, 9);
  endtask

  task automatic t_recovery();
    for (int s = 10; s < 16; s++) begin
      clr_n = 1'b1; load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din = 4'(s);
      tick();
      load_n = 1'b1;
      tick();
      check("R7 first count", q, ref_count(4'(s)));
      tick();
      check("R8 legal within two counts", (q <= 4'd9) ? 1 : 0, 1);
    end
  endtask

  task automatic t_cascade();
    c_clr_n = 1'b0;
    tick();
    c_clr_n = 1'b1;
    check("R10 cascade start", hi_q * 10 + lo_q, 0);
    for (int i = 1; i <= 105; i++) begin
      tick();
      check("R10 cascade value", hi_q * 10 + lo_q, i % 100);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequence();
    t_exhaustive();
    t_tc_comb();
    t_recovery();
    t_cascade();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule